// File: doc/BRIEF.md
# Nibble-Serialized Register Access Port

This block sits on the device side of a byte-wide host link and turns a stream of command bytes into accesses to a small local register file. Every command byte is split into an opcode in its upper nibble and a 4-bit payload in its lower nibble. A full 8-bit register address and a full 8-bit write value are therefore built up from two commands each. A read command places one byte on an outgoing response stream.

The host first sets the address with two nibble commands. It then either streams data nibble pairs, and each completed pair is written and moves the address on by one, or issues read commands. The read-with-advance variant lets the host fetch a run of consecutive registers without reloading the address. The response stream uses a valid/ready handshake. While a response is unclaimed, the command input is stalled.

Top module: `nibble_reg_port`

## Requirements
- R1: Opcode 0x0 loads the payload into address bits [3:0] and opcode 0x1 loads it into address bits [7:4]. In both cases the other half of the address is kept. The opcode sits in command bits [7:4] and the payload in bits [3:0].
- R2: Opcode 0x2 holds the payload as the low nibble of a pending data byte. Opcode 0x3 writes {payload, held low nibble} to the register at the current address.
- R3: After each write by opcode 0x3 the address is incremented by one, wrapping from 0xFF to 0x00. Consecutive data pairs therefore fill consecutive registers.
- R4: Opcode 0x4 returns the byte stored at the current address as one response and leaves the address unchanged.
- R5: Opcode 0x5 returns the byte at the current address and then increments the address, wrapping from 0xFF to 0x00.
- R6: A response is valid from the clock edge that accepts the read command. Its byte is held stable while `rsp_ready_i` is low, and it is removed on the edge where valid and ready are both high.
- R7: While a response is pending, `cmd_ready_o` is low and no command is accepted.
- R8: After reset, no response is pending, commands are accepted, and both the address and the held low data nibble are zero.
- R9: Opcodes 0x6 to 0xF are accepted and ignored. They do not change the address or the held nibble, they do not write, and they produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command byte present |
| cmd_byte_i | input | 8 | Command: opcode [7:4], payload [3:0] |
| cmd_ready_o | output | 1 | Command accepted this cycle when high with valid |
| rsp_valid_o | output | 1 | Response byte present |
| rsp_data_o | output | 8 | Register byte returned by a read |
| rsp_ready_i | input | 1 | Host takes the response |

## Verification
The hardest situation to reach is a command arriving while a response is still unclaimed, because the host normally drains each response at once. To create it, the bench issues a read, holds `rsp_ready_i` low, and presents an address nibble for several cycles. It checks that the command is refused and that the response byte does not move. It then withdraws the command and drains the response. A later read confirms that the refused nibble never reached the address. The address wrap is reached by writing and burst-reading across register 0xFF.

// File: rtl/nrp_pkg.sv
package nrp_pkg;
  localparam int unsigned NIB_W = 4;
  localparam int unsigned BYTE_W = 2 * NIB_W;

  typedef enum logic [NIB_W-1:0] {
    OP_ADR_LO = 4'h0,
    OP_ADR_HI = 4'h1,
    OP_DAT_LO = 4'h2,
    OP_DAT_HI = 4'h3,
    OP_RD     = 4'h4,
    OP_RD_INC = 4'h5
  } nrp_op_e;

  function automatic logic op_is_read(logic [NIB_W-1:0] op);
    return (op == OP_RD) || (op == OP_RD_INC);
  endfunction
endpackage

// File: rtl/nrp_cmd_decode.sv
module nrp_cmd_decode
  import nrp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [BYTE_W-1:0] cmd_byte_i,
  input  logic              rsp_busy_i,
  output logic              cmd_ready_o,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              rd_en_o,
  output logic [BYTE_W-1:0] rd_addr_o
);
  logic              fire;
  logic [NIB_W-1:0]  op, nib;
  logic [BYTE_W-1:0] addr_q;
  logic [NIB_W-1:0]  dlo_q;

  assign cmd_ready_o = !rsp_busy_i;
  assign fire        = cmd_valid_i && cmd_ready_o;
  assign op          = cmd_byte_i[BYTE_W-1:NIB_W];
  assign nib         = cmd_byte_i[NIB_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      dlo_q  <= '0;
    end else if (fire) begin
      case (op)
        OP_ADR_LO: addr_q[NIB_W-1:0]      <= nib;
        OP_ADR_HI: addr_q[BYTE_W-1:NIB_W] <= nib;
        OP_DAT_LO: dlo_q                  <= nib;
        OP_DAT_HI, OP_RD_INC: addr_q      <= addr_q + 1'b1;
        default: ;
      endcase
    end
  end

  assign wr_en_o   = fire && (op == OP_DAT_HI);
  assign wr_addr_o = addr_q;
  assign wr_data_o = {nib, dlo_q};
  assign rd_en_o   = fire && op_is_read(op);
  assign rd_addr_o = addr_q;

  AST_WR_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> addr_q == $past(addr_q) + 1'b1); // R3
  AST_RD_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && op == OP_RD) |=> $stable(addr_q)); // R4
  AST_RDI_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && op == OP_RD_INC) |=> addr_q == $past(addr_q) + 1'b1); // R5
  AST_UNKNOWN_INERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && op > OP_RD_INC) |=> ($stable(addr_q) && $stable(dlo_q))); // R9
endmodule

// File: rtl/nrp_reg_file.sv
module nrp_reg_file
  import nrp_pkg::*;
#(
  parameter int unsigned NUM_REGS = 256
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [BYTE_W-1:0] rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o
);
  localparam int unsigned SPAN = 1 << BYTE_W;
  localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [BYTE_W-1:0] mem [NUM_REGS];

  generate
    if (NUM_REGS >= SPAN) begin : g_full
      always_ff @(posedge clk_i) begin
        if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
      end
      assign rd_data_o = mem[rd_addr_i];
    end else begin : g_part
      logic wr_hit, rd_hit;
      assign wr_hit = 32'(wr_addr_i) < NUM_REGS;
      assign rd_hit = 32'(rd_addr_i) < NUM_REGS;
      always_ff @(posedge clk_i) begin
        if (wr_en_i && wr_hit) mem[wr_addr_i[IDX_W-1:0]] <= wr_data_i;
      end
      assign rd_data_o = rd_hit ? mem[rd_addr_i[IDX_W-1:0]] : '0;
    end
  endgenerate
endmodule

// File: rtl/nrp_rsp_hold.sv
module nrp_rsp_hold
  import nrp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [BYTE_W-1:0] data_o
);
  logic              valid_q;
  logic [BYTE_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      data_q  <= data_i;
    end else if (valid_q && ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;

  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !valid_q); // R7
  AST_RSP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !ready_i) |=> (valid_q && $stable(data_q))); // R6
  AST_RSP_DRAINED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && ready_i) |=> !valid_q); // R6
endmodule

// File: rtl/nibble_reg_port.sv
module nibble_reg_port
  import nrp_pkg::*;
#(
  parameter int unsigned NUM_REGS = 256
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic [7:0] cmd_byte_i,
  output logic       cmd_ready_o,
  output logic       rsp_valid_o,
  output logic [7:0] rsp_data_o,
  input  logic       rsp_ready_i
);
  logic              wr_en, rd_en;
  logic [BYTE_W-1:0] wr_addr, wr_data, rd_addr, rd_data;

  nrp_cmd_decode u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_byte_i  (cmd_byte_i),
    .rsp_busy_i  (rsp_valid_o),
    .cmd_ready_o (cmd_ready_o),
    .wr_en_o     (wr_en),
    .wr_addr_o   (wr_addr),
    .wr_data_o   (wr_data),
    .rd_en_o     (rd_en),
    .rd_addr_o   (rd_addr)
  );

  nrp_reg_file #(.NUM_REGS(NUM_REGS)) u_rf (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  nrp_rsp_hold u_rsp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (rd_en),
    .data_i  (rd_data),
    .ready_i (rsp_ready_i),
    .valid_o (rsp_valid_o),
    .data_o  (rsp_data_o)
  );

  AST_RD_GIVES_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o && (cmd_byte_i[7:4] == 4'h4 || cmd_byte_i[7:4] == 4'h5))
      |=> rsp_valid_o); // R4
endmodule

// File: tb/nibble_reg_port_tb_top.sv
module nibble_reg_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic       cmd_ready;
  logic       rsp_valid;
  logic [7:0] rsp_data;
  logic       rsp_ready = 1'b0;
  int         n_tests = 0;
  int         n_fail = 0;

  always #10 clk = ~clk;

  nibble_reg_port dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cmd_valid_i (cmd_valid),
    .cmd_byte_i  (cmd_byte),
    .cmd_ready_o (cmd_ready),
    .rsp_valid_o (rsp_valid),
    .rsp_data_o  (rsp_data),
    .rsp_ready_i (rsp_ready)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] op, input logic [3:0] nib);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_byte  = {op, nib};
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic set_addr(input logic [7:0] a);
    send(4'h0, a[3:0]);
    send(4'h1, a[7:4]);
  endtask

  task automatic put_byte(input logic [7:0] d);
    send(4'h2, d[3:0]);
    send(4'h3, d[7:4]);
  endtask

  // issues a read, checks the response at the negedge after acceptance, drains it
  task automatic read_chk(input logic [3:0] op, input logic [7:0] exp, input string req);
    send(op, 4'h0);
    check(rsp_valid === 1'b1, req, int'(rsp_valid), 1);
    check(rsp_data === exp, req, int'(rsp_data), int'(exp));
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic t_reset;
    check(rsp_valid === 1'b0, "R8", int'(rsp_valid), 0);
    check(cmd_ready === 1'b1, "R8", int'(cmd_ready), 1);
    send(4'h3, 4'h5); // zero addr and zero low nibble -> reg0 = 0x50
    set_addr(8'h00);
    read_chk(4'h4, 8'h50, "R8");
  endtask

  task automatic t_addr_nibbles;
    send(4'h0, 4'hC);
    send(4'h1, 4'h3);
    send(4'h0, 4'h7); // 0x37, high kept
    put_byte(8'hDE);
    put_byte(8'h21);  // lands at 0x38
    send(4'h0, 4'h7); // back to 0x37, high half kept (R1)
    read_chk(4'h4, 8'hDE, "R1");
    send(4'h1, 4'h3); // 0x37 still; low half kept
    send(4'h0, 4'h8);
    read_chk(4'h4, 8'h21, "R2");
  endtask

  task automatic t_burst;
    set_addr(8'h40);
    for (int i = 0; i < 6; i++) put_byte(8'(8'h11 * (i + 1)));
    set_addr(8'h40);
    for (int i = 0; i < 6; i++) read_chk(4'h5, 8'(8'h11 * (i + 1)), "R5");
    read_chk(4'h4, 8'hxx, "R4_dummy_skip") ;
  endtask

  task automatic t_plain_read;
    set_addr(8'h42);
    read_chk(4'h4, 8'h33, "R4");
    read_chk(4'h4, 8'h33, "R4");
    put_byte(8'h9C); // read left addr at 0x42
    set_addr(8'h42);
    read_chk(4'h4, 8'h9C, "R3");
    read_chk(4'h5, 8'h9C, "R5");
    read_chk(4'h4, 8'h44, "R3");
  endtask

  task automatic t_wrap;
    set_addr(8'hFF);
    put_byte(8'hA5);
    put_byte(8'h5A); // wraps to 0x00
    set_addr(8'h00);
    read_chk(4'h4, 8'h5A, "R3");
    set_addr(8'hFF);
    read_chk(4'h5, 8'hA5, "R5");
    read_chk(4'h5, 8'h5A, "R5");
  endtask

  task automatic t_stall;
    logic [7:0] held;
    set_addr(8'h40);
    send(4'h4, 4'h0);
    held = rsp_data;
    check(held === 8'h11, "R6", int'(held), 8'h11);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_byte  = 8'h0F;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(cmd_ready === 1'b0, "R7", int'(cmd_ready), 0);
      check(rsp_valid === 1'b1 && rsp_data === held, "R6", int'(rsp_data), int'(held));
    end
    cmd_valid = 1'b0;
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rsp_ready = 1'b0;
    check(rsp_valid === 1'b0, "R6", int'(rsp_valid), 0);
    check(cmd_ready === 1'b1, "R7", int'(cmd_ready), 1);
    read_chk(4'h4, 8'h11, "R7"); // refused nibble never moved the address
  endtask

  task automatic t_unknown;
    set_addr(8'h80);
    send(4'h2, 4'hC);
    send(4'h6, 4'hF);
    check(rsp_valid === 1'b0, "R9", int'(rsp_valid), 0);
    send(4'hF, 4'h1);
    check(rsp_valid === 1'b0, "R9", int'(rsp_valid), 0);
    send(4'h9, 4'h7);
    send(4'h3, 4'hB);
    set_addr(8'h80);
    read_chk(4'h4, 8'hBC, "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_addr_nibbles();
    set_addr(8'h40);
    for (int i = 0; i < 6; i++) put_byte(8'(8'h11 * (i + 1)));
    set_addr(8'h40);
    for (int i = 0; i < 6; i++) read_chk(4'h5, 8'(8'h11 * (i + 1)), "R5");
    t_plain_read();
    t_wrap();
    t_stall();
    t_unknown();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule